// File: doc/BRIEF.md
# Radix Page-Table Walker

This block translates a virtual page number into a physical page number by walking a tree of page tables stored in physical memory. A request carries the virtual page number and the root table pointer of the current process; the walker then reads one 8-byte entry per level through a single-outstanding memory read port, using one 9-bit slice of the virtual page number as the entry index at each level.

A valid entry at an upper level gives the page number of the next table down. An invalid entry at any level ends the walk with a fault that reports the level where it stopped. At the last level a valid entry is the leaf: its physical page number and its permission and status flags are returned. With the default of four levels and a 40-bit physical address, a 36-bit virtual page number (48-bit virtual address with a 4 KB page) maps to a 28-bit physical page number. The page offset never enters the block.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `done`, `fault` and `mem_rd_valid` are low.
- R2: Each read address is {table page number, index, 3'b000}; the first table is `root_ppn` sampled in the cycle the request is accepted, and later changes of `root_ppn` do not affect that walk.
- R3: Level 0 indexes with `req_vpn[35:27]`, level 1 with `[26:18]`, level 2 with `[17:9]`, and the last level with `[8:0]`.
- R4: `mem_rd_valid` is a one-cycle pulse, only while busy, and no further read is issued until the response to the previous one has arrived.
- R5: A valid entry (bit 0 set) at any level except the last supplies the next table page number from entry bits [39:12].
- R6: An entry with bit 0 clear ends the walk: `done` and `fault` pulse together, `fault_level` holds the level of that entry, `res_ppn` and `res_flags` read zero, and no read follows it.
- R7: A valid last-level entry completes the walk without fault; `res_ppn` is entry bits [39:12] and `res_flags` is {use bit 4, dirty bit 3, write bit 2, read bit 1}.
- R8: `busy` is high from the cycle after acceptance through the `done` cycle; a request presented while busy is ignored.
- R9: `done` is a one-cycle pulse, and `res_ppn`/`res_flags` change only in a `done` cycle and hold until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a walk (accepted only when idle) |
| req_vpn | input | 36 | Virtual page number to translate |
| root_ppn | input | 28 | Page number of the top-level table for the current process |
| busy | output | 1 | Walk in progress |
| mem_rd_valid | output | 1 | Read request pulse |
| mem_rd_addr | output | 40 | Physical byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Returned table entry |
| done | output | 1 | Walk finished (one cycle) |
| fault | output | 1 | Walk ended on an invalid entry (with done) |
| fault_level | output | 2 | Level of the invalid entry |
| res_ppn | output | 28 | Translated physical page number |
| res_flags | output | 4 | {use, dirty, write, read} of the leaf |

## Verification
A wrong level counter or index selection shows at the ports as a read to the wrong entry address on the very next request pulse, which in turn returns a different entry and so a wrong page number or a fault at an unexpected level when the walk ends. A stale table pointer shows the same way one level later. A state machine stuck outside idle shows as `busy` never falling, and a missed response wait shows as a second read pulse before the response, both visible within a few cycles of the request.

// File: rtl/ptw_pkg.sv
// Shared entry layout and walker state encoding.
// Assumes 8-byte entries with the page number field starting at the page offset width.
package ptw_pkg;
    localparam int ENTRY_W   = 64;
    localparam int BIT_VALID = 0;
    localparam int BIT_READ  = 1;
    localparam int BIT_WRITE = 2;
    localparam int BIT_DIRTY = 3;
    localparam int BIT_USE   = 4;
    localparam int ENT_SHIFT = 3;   // log2 of the entry size in bytes

    typedef struct packed {
        logic used;
        logic dirty;
        logic wr;
        logic rd;
    } pte_flags_t;

    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_ISSUE = 2'd1,
        WS_WAIT  = 2'd2,
        WS_RESP  = 2'd3
    } walk_state_t;
endpackage

// File: rtl/ptw_index_sel.sv
// Picks the table index for the current level from the virtual page number.
// Level 0 takes the most significant slice; assumes level < LEVELS.
module ptw_index_sel #(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    localparam int VPN_W = LEVELS * IDX_W,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic [VPN_W-1:0] vpn,
    input  logic [LVL_W-1:0] level,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] slice [LEVELS];

    // Split the page number into one slice per level, top slice first.
    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign slice[g] = vpn[(LEVELS-1-g)*IDX_W +: IDX_W];
    end

    // Select the slice for the level being walked.
    always_comb idx = slice[level];
endmodule

// File: rtl/ptw_entry_decode.sv
// Splits a 64-bit table entry into valid bit, page number and flags.
// Assumes PA_W <= 64; reserved bits are not interpreted.
module ptw_entry_decode
    import ptw_pkg::*;
#(
    parameter int PA_W  = 40,
    parameter int OFS_W = 12,
    localparam int PPN_W = PA_W - OFS_W
) (
    input  logic [ENTRY_W-1:0] entry,
    output logic               ent_valid,
    output logic [PPN_W-1:0]   ent_ppn,
    output pte_flags_t         ent_flags
);
    logic rsv_unused;

    // Field extraction.
    always_comb begin
        ent_valid       = entry[BIT_VALID];
        ent_ppn         = entry[OFS_W +: PPN_W];
        ent_flags.used  = entry[BIT_USE];
        ent_flags.dirty = entry[BIT_DIRTY];
        ent_flags.wr    = entry[BIT_WRITE];
        ent_flags.rd    = entry[BIT_READ];
    end

    // Reserved bits gathered so every input bit has a reader.
    assign rsv_unused = ^{entry[ENTRY_W-1:PA_W], entry[OFS_W-1:BIT_USE+1]};
endmodule

// File: rtl/ptw_walk_fsm.sv
// Walk sequencer: accepts one request, issues one read per level,
// descends, faults or completes. Assumes the memory answers every read
// once with mem_rsp_valid and never without a read outstanding.
module ptw_walk_fsm
    import ptw_pkg::*;
#(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int PPN_W  = 28,
    localparam int VPN_W = LEVELS * IDX_W,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [PPN_W-1:0] root_ppn,
    input  logic             mem_rsp_valid,
    input  logic             ent_valid,
    input  logic [PPN_W-1:0] ent_ppn,
    input  pte_flags_t       ent_flags,
    output logic [VPN_W-1:0] vpn_q,
    output logic [LVL_W-1:0] level_q,
    output logic [PPN_W-1:0] tbl_ppn_q,
    output logic             busy,
    output logic             rd_fire,
    output logic             done,
    output logic             fault,
    output logic [LVL_W-1:0] fault_level,
    output logic [PPN_W-1:0] res_ppn,
    output pte_flags_t       res_flags
);
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    walk_state_t state_q;
    logic        fault_q;

    // State, walk context and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= WS_IDLE;
            vpn_q       <= '0;
            level_q     <= '0;
            tbl_ppn_q   <= '0;
            fault_q     <= 1'b0;
            fault_level <= '0;
            res_ppn     <= '0;
            res_flags   <= '0;
        end else begin
            case (state_q)
                WS_IDLE: begin
                    if (req_valid) begin
                        vpn_q     <= req_vpn;
                        tbl_ppn_q <= root_ppn;
                        level_q   <= '0;
                        state_q   <= WS_ISSUE;
                    end
                end
                WS_ISSUE: state_q <= WS_WAIT;
                WS_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!ent_valid) begin
                            fault_q     <= 1'b1;
                            fault_level <= level_q;
                            res_ppn     <= '0;
                            res_flags   <= '0;
                            state_q     <= WS_RESP;
                        end else if (level_q == LAST_LVL) begin
                            fault_q   <= 1'b0;
                            res_ppn   <= ent_ppn;
                            res_flags <= ent_flags;
                            state_q   <= WS_RESP;
                        end else begin
                            tbl_ppn_q <= ent_ppn;
                            level_q   <= level_q + 1'b1;
                            state_q   <= WS_ISSUE;
                        end
                    end
                end
                default: state_q <= WS_IDLE;
            endcase
        end
    end

    // Output decode from the state.
    always_comb begin
        busy    = (state_q != WS_IDLE);
        rd_fire = (state_q == WS_ISSUE);
        done    = (state_q == WS_RESP);
        fault   = (state_q == WS_RESP) && fault_q;
    end

    AST_RD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> !rd_fire); // R4
    AST_NO_RD_WHILE_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_WAIT && !mem_rsp_valid) |=> !rd_fire); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_FAULT_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done); // R6
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res_ppn) |-> done); // R9
    AST_CTX_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(vpn_q)); // R8
endmodule

// File: rtl/pt_walker.sv
// Multi-level page table walker top. Forms each entry address from the
// current table page number and the level's index slice, and wires the
// sequencer to the entry decoder. Assumes IDX_W + 3 equals the offset width.
module pt_walker
    import ptw_pkg::*;
#(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int PA_W   = 40,
    localparam int OFS_W = IDX_W + ENT_SHIFT,
    localparam int PPN_W = PA_W - OFS_W,
    localparam int VPN_W = LEVELS * IDX_W,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VPN_W-1:0]   req_vpn,
    input  logic [PPN_W-1:0]   root_ppn,
    output logic               busy,
    output logic               mem_rd_valid,
    output logic [PA_W-1:0]    mem_rd_addr,
    input  logic               mem_rsp_valid,
    input  logic [ENTRY_W-1:0] mem_rsp_data,
    output logic               done,
    output logic               fault,
    output logic [LVL_W-1:0]   fault_level,
    output logic [PPN_W-1:0]   res_ppn,
    output logic [3:0]         res_flags
);
    logic [VPN_W-1:0] vpn_q;
    logic [LVL_W-1:0] level_q;
    logic [PPN_W-1:0] tbl_ppn_q;
    logic [IDX_W-1:0] idx;
    logic             ent_valid;
    logic [PPN_W-1:0] ent_ppn;
    pte_flags_t       ent_flags;
    pte_flags_t       flags_q;

    ptw_index_sel #(.LEVELS(LEVELS), .IDX_W(IDX_W)) u_idx (
        .vpn   (vpn_q),
        .level (level_q),
        .idx   (idx)
    );

    ptw_entry_decode #(.PA_W(PA_W), .OFS_W(OFS_W)) u_dec (
        .entry     (mem_rsp_data),
        .ent_valid (ent_valid),
        .ent_ppn   (ent_ppn),
        .ent_flags (ent_flags)
    );

    ptw_walk_fsm #(.LEVELS(LEVELS), .IDX_W(IDX_W), .PPN_W(PPN_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_vpn       (req_vpn),
        .root_ppn      (root_ppn),
        .mem_rsp_valid (mem_rsp_valid),
        .ent_valid     (ent_valid),
        .ent_ppn       (ent_ppn),
        .ent_flags     (ent_flags),
        .vpn_q         (vpn_q),
        .level_q       (level_q),
        .tbl_ppn_q     (tbl_ppn_q),
        .busy          (busy),
        .rd_fire       (mem_rd_valid),
        .done          (done),
        .fault         (fault),
        .fault_level   (fault_level),
        .res_ppn       (res_ppn),
        .res_flags     (flags_q)
    );

    // Entry address: table base page, index scaled by the entry size.
    always_comb begin
        mem_rd_addr = {tbl_ppn_q, idx, {ENT_SHIFT{1'b0}}};
        res_flags   = flags_q;
    end

    AST_RD_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> busy); // R4
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R8
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
    localparam int LAT = 2;

    typedef struct packed {
        logic [35:0] vpn;
        logic        flt;
        logic [1:0]  lvl;
        logic [27:0] ppn;
        logic [3:0]  flg;
    } vec_t;

    localparam vec_t VEC [0:7] = '{
        '{ {9'd1,9'd2,9'd3,9'd4},         1'b0, 2'd0, 28'h0012345, 4'b0011 },
        '{ {9'd1,9'd2,9'd3,9'd5},         1'b0, 2'd0, 28'h0000777, 4'b1001 },
        '{ {9'd1,9'd2,9'd3,9'd6},         1'b1, 2'd3, 28'h0,       4'b0000 },
        '{ {9'd7,9'd0,9'd0,9'd0},         1'b1, 2'd0, 28'h0,       4'b0000 },
        '{ {9'd1,9'd9,9'd0,9'd0},         1'b1, 2'd1, 28'h0,       4'b0000 },
        '{ {9'd1,9'd2,9'd8,9'd0},         1'b1, 2'd2, 28'h0,       4'b0000 },
        '{ {9'd511,9'd511,9'd511,9'd511}, 1'b0, 2'd0, 28'hFFFFFFF, 4'b1111 },
        '{ {9'd1,9'd2,9'd3,9'd7},         1'b0, 2'd0, 28'h0000ABC, 4'b0100 }
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [35:0] req_vpn = '0;
    logic [27:0] root_ppn = 28'd1;
    logic        busy, mem_rd_valid, done, fault;
    logic [39:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic [1:0]  fault_level;
    logic [27:0] res_ppn;
    logic [3:0]  res_flags;

    int checks = 0;
    int failures = 0;
    int reads = 0;
    logic [39:0] first_addr;
    int cycles = 0;

    logic [63:0] mem [logic [39:0]];

    always #5 clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vpn(req_vpn),
        .root_ppn(root_ppn), .busy(busy), .mem_rd_valid(mem_rd_valid),
        .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault),
        .fault_level(fault_level), .res_ppn(res_ppn), .res_flags(res_flags)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] dir_e(input logic [27:0] p);
        return {24'd0, p, 7'd0, 5'b00001};
    endfunction

    function automatic logic [63:0] leaf_e(input logic [27:0] p, input logic [3:0] f);
        return {24'd0, p, 7'd0, f, 1'b1};
    endfunction

    task automatic put(input logic [27:0] t, input logic [8:0] i, input logic [63:0] e);
        mem[{t, i, 3'b000}] = e;
    endtask

    // Behavioural memory: one response LAT cycles after each read; flags overlapping reads (R4).
    int          pend = 0;
    logic [39:0] pend_addr;
    logic        prev_rd = 1'b0;
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (mem_rd_valid) begin
            chk(pend == 0 && !prev_rd, "R4", "read while busy", pend, 0);
            if (reads == 0) first_addr = mem_rd_addr;
            reads++;
            pend_addr = mem_rd_addr;
            pend = LAT;
        end else if (pend != 0) begin
            pend--;
            if (pend == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data = mem.exists(pend_addr) ? mem[pend_addr] : 64'd0;
            end
        end
        prev_rd = mem_rd_valid;
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Launch a walk and wait for done; returns with done sampled high.
    task automatic walk(input logic [35:0] v, output logic ok);
        reads = 0;
        @(negedge clk);
        req_vpn = v;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        ok = 1'b0;
        for (int k = 0; k < 200; k++) begin
            if (done) begin ok = 1'b1; break; end
            @(negedge clk);
        end
        chk(ok, "R8", "walk completes", ok, 1);
    endtask

    initial begin
        logic ok;
        logic [27:0] held;
        put(1, 1, dir_e(2)); put(2, 2, dir_e(3)); put(3, 3, dir_e(4));
        put(4, 4, leaf_e(28'h0012345, 4'b0011));
        put(4, 5, leaf_e(28'h0000777, 4'b1001));
        put(4, 6, {24'd0, 28'h0055555, 12'h01E});   // valid bit clear
        put(4, 7, leaf_e(28'h0000ABC, 4'b0100));
        put(1, 511, dir_e(5)); put(5, 511, dir_e(6)); put(6, 511, dir_e(7));
        put(7, 511, leaf_e(28'hFFFFFFF, 4'b1111));
        put(8, 1, dir_e(11)); put(11, 2, dir_e(12)); put(12, 3, dir_e(13));
        put(13, 4, leaf_e(28'h000BEEF, 4'b0001));

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !fault && !mem_rd_valid, "R1", "outputs in reset",
            {busy, done, fault, mem_rd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_rd_valid, "R1", "idle after reset",
            {busy, done, mem_rd_valid}, 0);

        // Vector table.
        for (int n = 0; n < 8; n++) begin
            walk(VEC[n].vpn, ok);
            chk(busy, "R8", "busy during done", busy, 1);
            chk(fault == VEC[n].flt, "R6", "fault flag", fault, VEC[n].flt);
            if (VEC[n].flt) begin
                chk(fault_level == VEC[n].lvl, "R6", "fault level", fault_level, VEC[n].lvl);
                chk(reads == int'(VEC[n].lvl) + 1, "R6", "reads before fault", reads, VEC[n].lvl + 1);
                chk(res_ppn == 0 && res_flags == 0, "R6", "result cleared", res_ppn, 0);
            end else begin
                chk(reads == 4, "R5", "reads per full walk", reads, 4);
                chk(res_ppn == VEC[n].ppn, "R7", "leaf ppn", res_ppn, VEC[n].ppn);
                chk(res_flags == VEC[n].flg, "R7", "leaf flags", res_flags, VEC[n].flg);
            end
            @(negedge clk);
            chk(!done && !busy, "R9", "done pulse ends", {done, busy}, 0);
        end

        // R2 R3: first read address of a walk from root 1, top slice 1.
        walk({9'd1, 9'd2, 9'd3, 9'd4}, ok);
        chk(first_addr == 40'h0000001008, "R2", "first entry address", first_addr, 40'h1008);
        chk(res_ppn == 28'h0012345, "R3", "slice order", res_ppn, 28'h0012345);
        held = res_ppn;
        repeat (5) @(negedge clk);
        chk(res_ppn == held, "R9", "result held", res_ppn, held);

        // R2: a different root selects a different tree.
        root_ppn = 28'd8;
        walk({9'd1, 9'd2, 9'd3, 9'd4}, ok);
        chk(first_addr == 40'h0000008008, "R2", "root address", first_addr, 40'h8008);
        chk(res_ppn == 28'h000BEEF, "R2", "second tree ppn", res_ppn, 28'h000BEEF);

        // R8 R2: request and root change during a walk are ignored.
        root_ppn = 28'd1;
        reads = 0;
        @(negedge clk);
        req_vpn = {9'd1, 9'd2, 9'd3, 9'd5};
        req_valid = 1'b1;
        @(negedge clk);
        req_vpn = {9'd7, 9'd0, 9'd0, 9'd0};
        root_ppn = 28'd8;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 200 && !done; k++) @(negedge clk);
        chk(res_ppn == 28'h0000777 && !fault, "R8", "first request wins", res_ppn, 28'h777);
        chk(reads == 4, "R2", "root change mid-walk", reads, 4);
        reads = 0;
        repeat (10) @(negedge clk);
        chk(!busy && reads == 0, "R8", "no second walk", reads, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule